// File: doc/BRIEF.md
# Power-Up Strap Latch and Frequency Select

This block owns three shared pads of a clock generator during the first moments after supply. While power-good is low, and for a settling window after it rises, the pads act as inputs: their output drivers are off and the board's strap resistors set their level. When the window ends, the block takes one sample of the three pad values, keeps it in registers, and on the next cycle turns the three pad drivers on so the pads can carry clock outputs. A pad left unconnected reads as 1, so 1 is the default selection for every strap.

The latched straps control the rest of the generator for as long as power-good stays high. The first strap selects the high-frequency group and, together with a dedicated 100/66 select input that is not latched and has no pull-up, picks the CPU/PCI frequency pair. The second strap enables spread spectrum when it is low; spreading is 0.7 % downward, so the peak frequency stays at the nominal value. The third strap selects whether the auxiliary clock runs at 48 MHz or 24 MHz.

The sequencer is a three-state machine. `ST_SETTLE` is the reset state, entered whenever power-good is low, and counts the settling window. The transition `settle_done` moves it to `ST_CAPTURE` on the counter's terminal count. In `ST_CAPTURE` the pads are sampled, and the transition `capture_taken` moves it to `ST_DRIVE`, where it stays: the drivers are on and the straps are frozen. The only way out of `ST_DRIVE` is the transition `power_lost`, a low level on power-good, which returns the machine to `ST_SETTLE`.

Top module: `strap_select_top`

## Requirements
- R1: While pwr_good is low, pin_oe is 000 and straps_valid is 0, and the strap registers hold the default value 111. The outputs then show the defaults: spread_en is 0, aux_is_24m is 1, and the frequencies follow the table in R6 with the high-frequency strap at 1.
- R2: After pwr_good rises, pin_oe stays 000 through the first SETTLE_CYCLES+1 rising clock edges. It becomes 111 after the edge numbered SETTLE_CYCLES+1, at the same time as straps_valid becomes 1.
- R3: The value latched is the one pin_in has during the single cycle between rising edge SETTLE_CYCLES and rising edge SETTLE_CYCLES+1. Values present earlier in the settling window have no effect.
- R4: All three bits of pin_oe turn on in the same cycle, which is the cycle after the capture cycle, and they stay on while pwr_good is high.
- R5: Once straps_valid is 1, changes on pin_in have no effect on spread_en, aux_is_24m, cpu_mhz_x10 or pci_mhz_x10.
- R6: With h the latched pin_in[0] and s the live sel_100_66, the outputs cpu_mhz_x10/pci_mhz_x10 are: (h=1,s=0) 666/333, (1,1) 1000/333, (0,0) 1500/375, (0,1) 1333/333. A change on sel_100_66 shows on these outputs in the same cycle, because s is not latched.
- R7: spread_en is 1 exactly when the latched pin_in[1] is 0.
- R8: aux_is_24m equals the latched pin_in[2]: 1 selects 24 MHz and 0 selects 48 MHz.
- R9: If pwr_good falls at any time, the block returns at once to the R1 state. The next rise of pwr_good starts a new settling window and a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwr_good | input | 1 | Power-good; low acts as an asynchronous reset of the sequencer and the strap registers |
| pin_in | input | 3 | Levels sensed on the shared pads: [0] high-frequency select, [1] spread strap, [2] auxiliary rate strap |
| sel_100_66 | input | 1 | Dedicated 100/66 select, used live |
| pin_oe | output | 3 | Output-driver enable for each shared pad |
| straps_valid | output | 1 | The straps have been latched |
| cpu_mhz_x10 | output | 11 | CPU frequency in units of 0.1 MHz |
| pci_mhz_x10 | output | 9 | PCI frequency in units of 0.1 MHz |
| spread_en | output | 1 | Down-spread modulation enabled |
| aux_is_24m | output | 1 | Auxiliary clock at 24 MHz (0: 48 MHz) |

## Verification
The assertions check the following on every cycle. ST_CAPTURE is entered only when the settling counter is at its terminal count. The pad drivers rise only in the cycle after ST_CAPTURE and always switch as a group. The strap registers never change while the drivers are on. The CPU frequency output only ever takes one of the four legal values. The bench scenarios show what a property cannot express: the exact edge on which the drivers turn on, that only the value sampled in the capture cycle is kept and earlier values are ignored, the full frequency table with spread and auxiliary decodes, the live effect of the 100/66 select, and a fresh capture after power-good is lost and restored.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int N_STRAP = 3;
    localparam int CPU_W   = 11;
    localparam int PCI_W   = 9;

    typedef enum logic [1:0] {
        ST_SETTLE  = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_DRIVE   = 2'd2
    } pup_state_t;

    // Bit order matches the pad order on pin_in.
    typedef struct packed {
        logic aux_rate;    // pin_in[2]: 1 -> 24 MHz, 0 -> 48 MHz
        logic spread_off;  // pin_in[1]: 0 -> spreading enabled
        logic hfs_n;       // pin_in[0]: 0 -> high-frequency group
    } strap_t;

    localparam strap_t STRAP_DEFAULT = '1;

endpackage

// File: rtl/settle_seq.sv
module settle_seq
    import strap_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1024
) (
    input  logic clk,
    input  logic pwr_good,
    output logic capture_now,
    output logic drive_on
);
    localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] TERM = CNT_W'(SETTLE_CYCLES - 1);

    pup_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             term_hit;

    assign term_hit = (cnt == TERM);

    // state register
    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) state <= ST_SETTLE;
        else           state <= state_nx;
    end

    // settling counter, runs only in ST_SETTLE
    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good)
            cnt <= '0;
        else if (state == ST_SETTLE && !term_hit)
            cnt <= cnt + 1'b1;
    end

    // transitions: settle_done, capture_taken
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SETTLE:  if (term_hit) state_nx = ST_CAPTURE;
            ST_CAPTURE: state_nx = ST_DRIVE;
            ST_DRIVE:   state_nx = ST_DRIVE;
            default:    state_nx = ST_SETTLE;
        endcase
    end

    // outputs
    always_comb begin
        capture_now = 1'b0;
        drive_on    = 1'b0;
        unique case (state)
            ST_SETTLE:  ;
            ST_CAPTURE: capture_now = 1'b1;
            ST_DRIVE:   drive_on    = 1'b1;
            default:    ;
        endcase
    end

    // R3: capture only follows the terminal count of the window
    assert_capture_after_window_R3: assert property (@(posedge clk) disable iff (!pwr_good)
        (state == ST_CAPTURE) |-> ($past(cnt) == TERM));

    // R4: drivers turn on only out of the capture state
    assert_drive_after_capture_R4: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(drive_on) |-> $past(state == ST_CAPTURE));

endmodule

// File: rtl/strap_regs.sv
module strap_regs
    import strap_pkg::*;
(
    input  logic               clk,
    input  logic               pwr_good,
    input  logic               capture_now,
    input  logic [N_STRAP-1:0] pin_in,
    output strap_t             strap_q
);
    logic [N_STRAP-1:0] bits_q;

    for (genvar g = 0; g < N_STRAP; g++) begin : g_bit
        always_ff @(posedge clk or negedge pwr_good) begin
            if (!pwr_good)       bits_q[g] <= STRAP_DEFAULT[g];
            else if (capture_now) bits_q[g] <= pin_in[g];
        end
    end

    assign strap_q = strap_t'(bits_q);

endmodule

// File: rtl/freq_decode.sv
module freq_decode
    import strap_pkg::*;
(
    input  strap_t            strap_q,
    input  logic              sel_100_66,
    output logic [CPU_W-1:0]  cpu_mhz_x10,
    output logic [PCI_W-1:0]  pci_mhz_x10,
    output logic              spread_en,
    output logic              aux_is_24m
);
    always_comb begin
        unique case ({strap_q.hfs_n, sel_100_66})
            2'b10: begin cpu_mhz_x10 = CPU_W'(666);  pci_mhz_x10 = PCI_W'(333); end
            2'b11: begin cpu_mhz_x10 = CPU_W'(1000); pci_mhz_x10 = PCI_W'(333); end
            2'b00: begin cpu_mhz_x10 = CPU_W'(1500); pci_mhz_x10 = PCI_W'(375); end
            default: begin cpu_mhz_x10 = CPU_W'(1333); pci_mhz_x10 = PCI_W'(333); end
        endcase
    end

    assign spread_en  = ~strap_q.spread_off;
    assign aux_is_24m = strap_q.aux_rate;

endmodule

// File: rtl/strap_select_top.sv
module strap_select_top
    import strap_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              pwr_good,
    input  logic [2:0]        pin_in,
    input  logic              sel_100_66,
    output logic [2:0]        pin_oe,
    output logic              straps_valid,
    output logic [10:0]       cpu_mhz_x10,
    output logic [8:0]        pci_mhz_x10,
    output logic              spread_en,
    output logic              aux_is_24m
);
    logic   capture_now;
    logic   drive_on;
    strap_t strap_q;

    settle_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
        .clk         (clk),
        .pwr_good    (pwr_good),
        .capture_now (capture_now),
        .drive_on    (drive_on)
    );

    strap_regs u_regs (
        .clk         (clk),
        .pwr_good    (pwr_good),
        .capture_now (capture_now),
        .pin_in      (pin_in),
        .strap_q     (strap_q)
    );

    freq_decode u_dec (
        .strap_q     (strap_q),
        .sel_100_66  (sel_100_66),
        .cpu_mhz_x10 (cpu_mhz_x10),
        .pci_mhz_x10 (pci_mhz_x10),
        .spread_en   (spread_en),
        .aux_is_24m  (aux_is_24m)
    );

    assign pin_oe       = {N_STRAP{drive_on}};
    assign straps_valid = drive_on;

    // R5: latched straps frozen while drivers are on
    assert_straps_frozen_R5: assert property (@(posedge clk) disable iff (!pwr_good)
        (pin_oe[0] && $past(pin_oe[0])) |-> $stable(strap_q));

    // R4: pad drivers switch as a group
    assert_oe_grouped_R4: assert property (@(posedge clk) disable iff (!pwr_good)
        (pin_oe == 3'b000) || (pin_oe == 3'b111));

    // R6: CPU frequency is always one of the four table entries
    assert_cpu_legal_R6: assert property (@(posedge clk) disable iff (!pwr_good)
        (cpu_mhz_x10 == 11'd666) || (cpu_mhz_x10 == 11'd1000) ||
        (cpu_mhz_x10 == 11'd1500) || (cpu_mhz_x10 == 11'd1333));

endmodule

// File: tb/strap_select_top_bench.sv
`timescale 1ns/1ps
module strap_select_top_bench;

    localparam int SETTLE = 8;

    logic        clk = 1'b0;
    logic        pwr_good = 1'b0;
    logic [2:0]  pin_in = 3'b111;
    logic        sel_100_66 = 1'b0;
    logic [2:0]  pin_oe;
    logic        straps_valid;
    logic [10:0] cpu_mhz_x10;
    logic [8:0]  pci_mhz_x10;
    logic        spread_en;
    logic        aux_is_24m;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    strap_select_top #(.SETTLE_CYCLES(SETTLE)) u_strap_select_top (
        .clk(clk), .pwr_good(pwr_good), .pin_in(pin_in), .sel_100_66(sel_100_66),
        .pin_oe(pin_oe), .straps_valid(straps_valid), .cpu_mhz_x10(cpu_mhz_x10),
        .pci_mhz_x10(pci_mhz_x10), .spread_en(spread_en), .aux_is_24m(aux_is_24m)
    );

    // {straps[2:0], sel, cpu x10, pci x10, spread_en, aux_is_24m}
    localparam logic [25:0] VEC [0:7] = '{
        {3'b111, 1'b0, 11'd666,  9'd333, 1'b0, 1'b1},
        {3'b111, 1'b1, 11'd1000, 9'd333, 1'b0, 1'b1},
        {3'b110, 1'b0, 11'd1500, 9'd375, 1'b0, 1'b1},
        {3'b110, 1'b1, 11'd1333, 9'd333, 1'b0, 1'b1},
        {3'b101, 1'b0, 11'd666,  9'd333, 1'b1, 1'b1},
        {3'b011, 1'b1, 11'd1000, 9'd333, 1'b0, 1'b0},
        {3'b000, 1'b0, 11'd1500, 9'd375, 1'b1, 1'b0},
        {3'b000, 1'b1, 11'd1333, 9'd333, 1'b1, 1'b0}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // power down, then power up with 'early' during the window and 'at_cap' in the capture cycle
    task automatic power_cycle(input logic [2:0] early, input logic [2:0] at_cap);
        @(negedge clk);
        pwr_good = 1'b0;
        pin_in   = early;
        @(negedge clk);
        check("R1 oe low in power-down", int'(pin_oe), 0);
        check("R1 valid low in power-down", int'(straps_valid), 0);
        pwr_good = 1'b1;
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
        check("R2 oe still off before capture edge", int'(pin_oe), 0);
        pin_in = at_cap;
        @(posedge clk);
        @(negedge clk);
        check("R2 R4 oe on after capture", int'(pin_oe), 7);
        check("R2 valid after capture", int'(straps_valid), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1: defaults while power-good low
        sel_100_66 = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 default cpu", int'(cpu_mhz_x10), 1000);
        check("R1 default pci", int'(pci_mhz_x10), 333);
        check("R1 default spread off", int'(spread_en), 0);
        check("R1 default aux 24", int'(aux_is_24m), 1);
        check("R1 oe off", int'(pin_oe), 0);

        // table walk: R6, R7, R8, then R5 after each capture
        for (int i = 0; i < 8; i++) begin
            logic [25:0] v;
            v = VEC[i];
            sel_100_66 = v[22];
            power_cycle(v[25:23], v[25:23]);
            check("R6 cpu", int'(cpu_mhz_x10), int'(v[21:11]));
            check("R6 pci", int'(pci_mhz_x10), int'(v[10:2]));
            check("R7 spread", int'(spread_en), int'(v[1]));
            check("R8 aux", int'(aux_is_24m), int'(v[0]));
            pin_in = ~v[25:23];
            repeat (3) @(negedge clk);
            check("R5 spread unchanged", int'(spread_en), int'(v[1]));
            check("R5 aux unchanged", int'(aux_is_24m), int'(v[0]));
            check("R5 cpu unchanged", int'(cpu_mhz_x10), int'(v[21:11]));
            check("R5 oe stays on", int'(pin_oe), 7);
        end

        // R3: earlier window values ignored, only capture-cycle value kept
        sel_100_66 = 1'b0;
        power_cycle(3'b000, 3'b111);
        check("R3 spread from capture cycle", int'(spread_en), 0);
        check("R3 aux from capture cycle", int'(aux_is_24m), 1);
        check("R3 cpu from capture cycle", int'(cpu_mhz_x10), 666);
        power_cycle(3'b111, 3'b000);
        check("R3 spread on", int'(spread_en), 1);
        check("R3 aux 48", int'(aux_is_24m), 0);
        check("R3 cpu 150", int'(cpu_mhz_x10), 1500);

        // R6: live select, same cycle
        @(negedge clk);
        sel_100_66 = 1'b1;
        #1;
        check("R6 live sel cpu", int'(cpu_mhz_x10), 1333);
        check("R6 live sel pci", int'(pci_mhz_x10), 333);

        // R9: loss of power-good mid-settle and after capture
        @(negedge clk);
        pwr_good = 1'b0;
        #1;
        check("R9 oe drops at once", int'(pin_oe), 0);
        check("R9 straps back to default", int'(aux_is_24m), 1);
        check("R9 spread default", int'(spread_en), 0);
        @(negedge clk);
        pwr_good = 1'b1;
        pin_in = 3'b001;
        repeat (SETTLE - 3) @(posedge clk);
        @(negedge clk);
        pwr_good = 1'b0;
        @(negedge clk);
        pwr_good = 1'b1;
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
        check("R9 window restarted", int'(pin_oe), 0);
        @(posedge clk);
        @(negedge clk);
        check("R9 recapture oe", int'(pin_oe), 7);
        check("R9 recapture spread", int'(spread_en), 1);
        check("R9 recapture aux", int'(aux_is_24m), 0);
        check("R9 recapture cpu", int'(cpu_mhz_x10), 1000);

        finish_run();
    end

endmodule